// File: doc/BRIEF.md
# Asynchronous 20-to-30-bit gearbox

This block moves a stream of 20-bit words from one clock domain into a stream of 30-bit words in a second, unrelated clock domain. The bit rate is the same on both sides. A typical pairing is a 300 MHz producer and a 200 MHz consumer, and the two clocks may have any phase relationship.

On the producer side the block collects three consecutive 20-bit words into one 60-bit group. A flag on the first word of each group marks where a group starts. Finished groups are written into an 8-entry, 60-bit-wide dual-clock FIFO. Its read and write pointers are Gray-coded and cross between domains through two-flop synchronizers. On the consumer side each stored group is emitted as two consecutive 30-bit words, and a flag marks the first of the two.

Both edges use valid/ready handshakes. A single asynchronous reset clears all state, and it is released separately and synchronously in each domain.

Top module: `gbx_20to30`

## Requirements
- R1: During reset and after it is released, `in_ready` is 1 and `out_valid` is 0. Reset clears any partly packed group, so a word without a start flag that arrives right after reset is discarded.
- R2: For a group of input words A, B and C (A carries the start flag), the first output word is {B[9:0], A} and the second is {C, B[19:10]}. Bit 0 of A is bit 0 of the first output word.
- R3: `in_ready` goes low only when the FIFO is full and the packer holds no word of an unfinished group. With the output stalled, exactly 8 complete groups are accepted before `in_ready` falls, and none of them is lost or overwritten.
- R4: `out_sog` is 1 on the first 30-bit word of every group and 0 on the second. A handshake on a first word is always followed by the second word of the same group.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_sog` hold their values.
- R6: An accepted word with `in_sog`=1 always becomes the first word of a new group, and any partial group already held is discarded. This applies whether the partial group holds one word or two.
- R7: An accepted word with `in_sog`=0 is discarded when no group is open (no start flag has been seen since the last complete group or reset).
- R8: `out_valid` is 0 while the FIFO is empty and no second half is pending. This includes the time a partial group is waiting in the packer.
- R9: Every complete group comes out exactly once and in input order, for any ratio of the two clocks and any pattern of output stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| in_clk | input | 1 | Producer-side clock |
| in_valid | input | 1 | Producer offers a word |
| in_sog | input | 1 | Offered word is the first of a group |
| in_data | input | 20 | Offered word |
| in_ready | output | 1 | Block accepts the offered word this cycle |
| out_clk | input | 1 | Consumer-side clock |
| out_valid | output | 1 | Output word is available |
| out_sog | output | 1 | Output word is the first half of a group |
| out_data | output | 30 | Output word |
| out_ready | input | 1 | Consumer takes the output word this cycle |

## Verification
The checks assume both clocks run freely. They also assume reset is held for several cycles of the slower clock, and that it is applied only when no group is in flight through the FIFO, so the two domains never disagree about its contents. The stimulus drives both handshakes half a period away from the sampling edge. It asserts reset only after the scoreboard has drained, and it keeps the producer clock slightly faster than a 3:2 ratio of the consumer clock, so the full condition is reached when the output stalls. Output stalls follow a pseudo-random pattern, so first and second halves are both held across several cycles.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    localparam int unsigned DEF_IN_W      = 20;
    localparam int unsigned DEF_OUT_W     = 30;
    localparam int unsigned DEF_IN_PER_GRP = 3;
    localparam int unsigned DEF_FIFO_AW   = 3;
    localparam int unsigned DEF_SYNC      = 2;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/gbx_rst_sync.sv
module gbx_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/gbx_sync_bus.sv
module gbx_sync_bus #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];
    logic [W-1:0] st_d [STAGES];

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < int'(STAGES); i++) st_d[i] = st_q[i-1];
    end

    generate
        for (genvar g = 0; g < int'(STAGES); g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[g] <= '0;
                else        st_q[g] <= st_d[g];
            end
        end
    endgenerate

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/gbx_afifo.sv
module gbx_afifo #(
    parameter int unsigned DW   = 60,
    parameter int unsigned AW   = 3,
    parameter int unsigned SYNC = 2
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic          full,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rdata,
    output logic          empty
);
    localparam int unsigned PW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } ptr_t;

    ptr_t          w_q, w_d, r_q, r_d;
    logic [PW-1:0] rg_in_w;
    logic [PW-1:0] wg_in_r;
    logic [DW-1:0] mem [DEPTH];

    // write domain
    always_comb begin
        full = (w_q.gray == {~rg_in_w[PW-1:PW-2], rg_in_w[PW-3:0]});
        w_d  = w_q;
        if (wr_en && !full) begin
            w_d.bin  = w_q.bin + 1'b1;
            w_d.gray = PW'(gbx_pkg::bin_to_gray(32'(w_d.bin)));
        end
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) w_q <= '0;
        else         w_q <= w_d;
    end

    always_ff @(posedge wclk) begin
        if (wr_en && !full) mem[w_q.bin[AW-1:0]] <= wdata;
    end

    // read domain
    always_comb begin
        empty = (r_q.gray == wg_in_r);
        r_d   = r_q;
        if (rd_en && !empty) begin
            r_d.bin  = r_q.bin + 1'b1;
            r_d.gray = PW'(gbx_pkg::bin_to_gray(32'(r_d.bin)));
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign rdata = mem[r_q.bin[AW-1:0]];

    gbx_sync_bus #(.W(PW), .STAGES(SYNC)) u_rg_sync (
        .clk(wclk), .rst_n(wrst_n), .d(r_q.gray), .q(rg_in_w)
    );

    gbx_sync_bus #(.W(PW), .STAGES(SYNC)) u_wg_sync (
        .clk(rclk), .rst_n(rrst_n), .d(w_q.gray), .q(wg_in_r)
    );
endmodule

// File: rtl/gbx_packer.sv
module gbx_packer #(
    parameter int unsigned IN_W  = 20,
    parameter int unsigned GRP_N = 3,
    parameter int unsigned CW    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sog,
    input  logic [IN_W-1:0]       in_data,
    output logic                  in_ready,
    input  logic                  fifo_full,
    output logic                  grp_wr,
    output logic [IN_W*GRP_N-1:0] grp_data,
    output logic [CW-1:0]         pos
);
    localparam int unsigned ACC_W = IN_W * (GRP_N - 1);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [ACC_W-1:0] acc;
    } pk_t;

    pk_t  st_q, st_d;
    logic take;

    always_comb begin
        st_d     = st_q;
        // a started group is always finished: full is checked only before word one
        in_ready = (st_q.cnt != '0) || !fifo_full;
        take     = in_valid && in_ready;
        grp_wr   = 1'b0;
        grp_data = {in_data, st_q.acc};
        if (take) begin
            if (in_sog) begin
                st_d.cnt            = CW'(1);
                st_d.acc[IN_W-1:0]  = in_data;
            end else if (st_q.cnt == '0) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == CW'(GRP_N - 1)) begin
                grp_wr   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.acc[int'(st_q.cnt)*IN_W +: IN_W] = in_data;
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos = st_q.cnt;
endmodule

// File: rtl/gbx_unpacker.sv
module gbx_unpacker #(
    parameter int unsigned OUT_W = 30,
    parameter int unsigned GRP_N = 2,
    parameter int unsigned CW    = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fifo_empty,
    input  logic [OUT_W*GRP_N-1:0] fifo_rdata,
    output logic                   fifo_rd,
    output logic                   out_valid,
    output logic                   out_sog,
    output logic [OUT_W-1:0]       out_data,
    input  logic                   out_ready
);
    localparam int unsigned GRP_W  = OUT_W * GRP_N;
    localparam int unsigned HOLD_W = OUT_W * (GRP_N - 1);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [HOLD_W-1:0] hold;
    } up_t;

    up_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        fifo_rd = 1'b0;
        if (st_q.cnt == '0) begin
            out_valid = !fifo_empty;
            out_sog   = 1'b1;
            out_data  = fifo_rdata[OUT_W-1:0];
            if (out_valid && out_ready) begin
                fifo_rd   = 1'b1;
                st_d.hold = fifo_rdata[GRP_W-1:OUT_W];
                st_d.cnt  = CW'(1);
            end
        end else begin
            out_valid = 1'b1;
            out_sog   = 1'b0;
            out_data  = st_q.hold[(int'(st_q.cnt)-1)*OUT_W +: OUT_W];
            if (out_ready) begin
                st_d.cnt = (st_q.cnt == CW'(GRP_N - 1)) ? '0 : st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gbx_20to30.sv
module gbx_20to30 #(
    parameter int unsigned IN_W       = gbx_pkg::DEF_IN_W,
    parameter int unsigned OUT_W      = gbx_pkg::DEF_OUT_W,
    parameter int unsigned IN_PER_GRP = gbx_pkg::DEF_IN_PER_GRP,
    parameter int unsigned FIFO_AW    = gbx_pkg::DEF_FIFO_AW,
    parameter int unsigned SYNC       = gbx_pkg::DEF_SYNC
) (
    input  logic             arst_n,
    input  logic             in_clk,
    input  logic             in_valid,
    input  logic             in_sog,
    input  logic [IN_W-1:0]  in_data,
    output logic             in_ready,
    input  logic             out_clk,
    output logic             out_valid,
    output logic             out_sog,
    output logic [OUT_W-1:0] out_data,
    input  logic             out_ready
);
    localparam int unsigned GRP_W       = IN_W * IN_PER_GRP;
    localparam int unsigned OUT_PER_GRP = GRP_W / OUT_W;
    localparam int unsigned PK_CW       = $clog2(IN_PER_GRP);
    localparam int unsigned UP_CW       = (OUT_PER_GRP > 2) ? $clog2(OUT_PER_GRP) : 1;

    logic             in_rst_n_s;
    logic             out_rst_n_s;
    logic             grp_wr;
    logic [GRP_W-1:0] grp_wdata;
    logic             fifo_full;
    logic             grp_rd;
    logic [GRP_W-1:0] grp_rdata;
    logic             fifo_empty;
    logic [PK_CW-1:0] pk_pos;

    gbx_rst_sync #(.STAGES(SYNC)) u_rst_in (
        .clk(in_clk), .arst_n(arst_n), .rst_n(in_rst_n_s)
    );

    gbx_rst_sync #(.STAGES(SYNC)) u_rst_out (
        .clk(out_clk), .arst_n(arst_n), .rst_n(out_rst_n_s)
    );

    gbx_packer #(.IN_W(IN_W), .GRP_N(IN_PER_GRP), .CW(PK_CW)) u_pack (
        .clk      (in_clk),
        .rst_n    (in_rst_n_s),
        .in_valid (in_valid),
        .in_sog   (in_sog),
        .in_data  (in_data),
        .in_ready (in_ready),
        .fifo_full(fifo_full),
        .grp_wr   (grp_wr),
        .grp_data (grp_wdata),
        .pos      (pk_pos)
    );

    gbx_afifo #(.DW(GRP_W), .AW(FIFO_AW), .SYNC(SYNC)) u_fifo (
        .wclk  (in_clk),
        .wrst_n(in_rst_n_s),
        .wr_en (grp_wr),
        .wdata (grp_wdata),
        .full  (fifo_full),
        .rclk  (out_clk),
        .rrst_n(out_rst_n_s),
        .rd_en (grp_rd),
        .rdata (grp_rdata),
        .empty (fifo_empty)
    );

    gbx_unpacker #(.OUT_W(OUT_W), .GRP_N(OUT_PER_GRP), .CW(UP_CW)) u_unpack (
        .clk       (out_clk),
        .rst_n     (out_rst_n_s),
        .fifo_empty(fifo_empty),
        .fifo_rdata(grp_rdata),
        .fifo_rd   (grp_rd),
        .out_valid (out_valid),
        .out_sog   (out_sog),
        .out_data  (out_data),
        .out_ready (out_ready)
    );
endmodule

// File: rtl/gbx_checker.sv
module gbx_checker #(
    parameter int unsigned OUT_W = 30,
    parameter int unsigned CW    = 2
) (
    input logic             in_clk,
    input logic             out_clk,
    input logic             in_rst_n,
    input logic             out_rst_n,
    input logic             grp_wr,
    input logic             fifo_full,
    input logic             grp_rd,
    input logic             fifo_empty,
    input logic             in_ready,
    input logic [CW-1:0]    pk_pos,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_sog,
    input logic [OUT_W-1:0] out_data
);
    AST_NO_OVERFLOW: assert property (@(posedge in_clk) disable iff (!in_rst_n)
        grp_wr |-> !fifo_full); // R3

    AST_READY_AT_BOUNDARY: assert property (@(posedge in_clk) disable iff (!in_rst_n)
        !in_ready |-> (pk_pos == '0)); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        grp_rd |-> !fifo_empty); // R8

    AST_OUT_HELD: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sog))); // R5

    AST_SECOND_FOLLOWS: assert property (@(posedge out_clk) disable iff (!out_rst_n)
        (out_valid && out_ready && out_sog) |=> (out_valid && !out_sog)); // R4
endmodule

bind gbx_20to30 gbx_checker #(.OUT_W(OUT_W), .CW(PK_CW)) u_chk (
    .in_clk    (in_clk),
    .out_clk   (out_clk),
    .in_rst_n  (in_rst_n_s),
    .out_rst_n (out_rst_n_s),
    .grp_wr    (grp_wr),
    .fifo_full (fifo_full),
    .grp_rd    (grp_rd),
    .fifo_empty(fifo_empty),
    .in_ready  (in_ready),
    .pk_pos    (pk_pos),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sog   (out_sog),
    .out_data  (out_data)
);

// File: tb/tb_gbx_20to30.sv
`timescale 1ns/1ps
module tb_gbx_20to30;
    localparam int IN_W  = 20;
    localparam int OUT_W = 30;

    logic             in_clk  = 1'b0;
    logic             out_clk = 1'b0;
    logic             arst_n  = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_sog   = 1'b0;
    logic [IN_W-1:0]  in_data  = '0;
    logic             in_ready;
    logic             out_valid;
    logic             out_sog;
    logic [OUT_W-1:0] out_data;
    logic             out_ready = 1'b0;

    always #10  out_clk = ~out_clk;   // 50 MHz
    always #6.5 in_clk  = ~in_clk;

    gbx_20to30 dut (
        .arst_n(arst_n), .in_clk(in_clk), .in_valid(in_valid), .in_sog(in_sog),
        .in_data(in_data), .in_ready(in_ready), .out_clk(out_clk),
        .out_valid(out_valid), .out_sog(out_sog), .out_data(out_data),
        .out_ready(out_ready)
    );

    typedef struct packed {
        logic             sog;
        logic [OUT_W-1:0] data;
    } item_t;

    item_t      exp_q[$];
    int         n_chk = 0;
    int         n_bad = 0;
    logic       out_hold = 1'b1;
    logic       rdy_rand = 1'b0;
    logic [7:0] lf = 8'hA5;
    logic       prev_stall = 1'b0;
    item_t      prev_item;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic expect_group(input logic [IN_W-1:0] a, input logic [IN_W-1:0] b,
                                input logic [IN_W-1:0] c);
        exp_q.push_back({1'b1, b[9:0], a});
        exp_q.push_back({1'b0, c, b[19:10]});
    endtask

    // pos: words the packer holds when this one is offered
    task automatic put_word(input logic [IN_W-1:0] d, input logic s, input int pos);
        in_valid = 1'b1;
        in_data  = d;
        in_sog   = s;
        forever begin
            if (in_ready) break;
            if (pos != 0) check(1'b0, "R3", "ready low inside a group", 64'(in_ready), 64'd1);
            @(negedge in_clk);
        end
        @(negedge in_clk);
        in_valid = 1'b0;
    endtask

    task automatic send_group(input logic [IN_W-1:0] a, input logic [IN_W-1:0] b,
                              input logic [IN_W-1:0] c);
        expect_group(a, b, c);
        put_word(a, 1'b1, 0);
        put_word(b, 1'b0, 1);
        put_word(c, 1'b0, 2);
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge out_clk);
        check(exp_q.size() == 0, req, "words still expected", 64'(exp_q.size()), 64'd0);
        repeat (8) @(negedge out_clk);
        check(out_valid == 1'b0, "R8", "valid with nothing stored", 64'(out_valid), 64'd0);
        @(negedge in_clk);
    endtask

    // monitor / scoreboard
    always @(negedge out_clk) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        out_ready = !out_hold && (!rdy_rand || lf[1:0] != 2'b00);
        if (prev_stall && arst_n) begin
            check(out_valid && out_sog == prev_item.sog && out_data == prev_item.data,
                  "R5", "output changed while stalled",
                  64'({out_valid, out_sog, out_data}), 64'({1'b1, prev_item}));
        end
        if (arst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected word", 64'({out_sog, out_data}), 64'd0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(out_data == e.data, "R2", "data", 64'(out_data), 64'(e.data));
                check(out_sog == e.sog, "R4", "start flag", 64'(out_sog), 64'(e.sog));
            end
        end
        prev_stall = arst_n && out_valid && !out_ready;
        prev_item  = {out_sog, out_data};
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge in_clk);
        check(1'b0, "R9", "watchdog expired", 64'd0, 64'd1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge out_clk);
        check(in_ready == 1'b1, "R1", "ready during reset", 64'(in_ready), 64'd1);
        check(out_valid == 1'b0, "R1", "valid during reset", 64'(out_valid), 64'd0);
        arst_n = 1'b1;
        repeat (6) @(negedge out_clk);
        check(in_ready == 1'b1, "R1", "ready after reset", 64'(in_ready), 64'd1);
        check(out_valid == 1'b0, "R1", "valid after reset", 64'(out_valid), 64'd0);
        @(negedge in_clk);

        // R2 R4: basic patterns, consumer always ready
        out_hold = 1'b0;
        send_group(20'h00001, 20'h00002, 20'h00003);
        send_group(20'hFFFFF, 20'h00000, 20'hFFFFF);
        send_group(20'hAAAAA, 20'h55555, 20'hAAAAA);
        send_group(20'h12345, 20'h3FF00, 20'h0ABCD);
        drain("R2");

        // R7: stray words without a start flag while idle
        put_word(20'h77777, 1'b0, 0);
        put_word(20'h88888, 1'b0, 0);
        send_group(20'h11111, 20'h22222, 20'h33333);
        drain("R7");

        // R6: start flag after two words, then after one word
        expect_group(20'hC0001, 20'hC0002, 20'hC0003);
        put_word(20'hDEAD0, 1'b1, 0);
        put_word(20'hDEAD1, 1'b0, 1);
        put_word(20'hC0001, 1'b1, 2);
        put_word(20'hC0002, 1'b0, 1);
        put_word(20'hC0003, 1'b0, 2);
        expect_group(20'hE0001, 20'hE0002, 20'hE0003);
        put_word(20'hBEEF0, 1'b1, 0);
        put_word(20'hE0001, 1'b1, 1);
        put_word(20'hE0002, 1'b0, 1);
        put_word(20'hE0003, 1'b0, 2);
        drain("R6");

        // R8: partial group waiting in the packer produces nothing
        put_word(20'h0F0F0, 1'b1, 0);
        put_word(20'h0F0F1, 1'b0, 1);
        repeat (30) @(negedge out_clk);
        check(out_valid == 1'b0, "R8", "valid with partial group", 64'(out_valid), 64'd0);
        @(negedge in_clk);
        send_group(20'h40001, 20'h40002, 20'h40003);
        drain("R8");

        // R3: fill the FIFO with the consumer stalled
        out_hold = 1'b1;
        for (int g = 0; g < 8; g++)
            send_group(20'(g * 3 + 20'h50000), 20'(g * 3 + 20'h50001), 20'(g * 3 + 20'h50002));
        repeat (6) @(negedge in_clk);
        check(in_ready == 1'b0, "R3", "ready with 8 groups stored", 64'(in_ready), 64'd0);
        fork
            begin
                send_group(20'h6AAAA, 20'h6BBBB, 20'h6CCCC);
                send_group(20'h7AAAA, 20'h7BBBB, 20'h7CCCC);
            end
            begin
                repeat (20) @(negedge out_clk);
                rdy_rand = 1'b1;
                out_hold = 1'b0;
            end
        join
        drain("R3");

        // R1: reset in the middle of a partial group
        put_word(20'h90000, 1'b1, 0);
        put_word(20'h90001, 1'b0, 1);
        arst_n = 1'b0;
        repeat (4) @(negedge out_clk);
        arst_n = 1'b1;
        repeat (6) @(negedge out_clk);
        check(in_ready == 1'b1, "R1", "ready after mid reset", 64'(in_ready), 64'd1);
        check(out_valid == 1'b0, "R1", "valid after mid reset", 64'(out_valid), 64'd0);
        @(negedge in_clk);
        put_word(20'h9FFFF, 1'b0, 0);
        send_group(20'hA1111, 20'hA2222, 20'hA3333);
        drain("R1");

        // R9: long stream with random consumer stalls
        for (int g = 0; g < 40; g++) begin
            logic [IN_W-1:0] base;
            base = 20'(g * 20'h2F3B1) ^ 20'(g << 9);
            send_group(base, ~base, base ^ 20'h5A5A5);
        end
        drain("R9");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule